// File: doc/BRIEF.md
# Shift-Subtract Divide Step Engine

This block divides an unsigned 32-bit dividend by an unsigned 16-bit divisor. The default width parameter W is 16, so the dividend is 2W bits wide. On a start request the upper half of the dividend goes into a partial-remainder register and the lower half into a quotient/low register. The divisor is latched at the same time. The engine then runs one restoring step per clock for W clocks:

- It shifts the register pair left by one bit.
- It compares the (W+1)-bit partial remainder with the divisor.
- When the divisor fits, it subtracts the divisor and shifts a 1 into the low end of the quotient register. Otherwise a 0 enters there.

After the last step the high register holds the remainder and the low register holds the quotient.

A guard stage checks each request before any step runs. A zero divisor, or a divisor not larger than the upper half of the dividend, gives a quotient that cannot fit in W bits. In that case the request finishes at once with the overflow flag set and all-ones results.

The control is a three-state machine:

- ST_IDLE: waits for a request. An accepted start moves it to ST_RUN for a valid division, or straight to ST_DONE on overflow.
- ST_RUN: executes the steps. After the W-th step it moves to ST_DONE.
- ST_DONE: asserts the done pulse for one cycle and then returns to ST_IDLE.

Top module: `shlsub_divider`

## Requirements
- R1: After reset, busy, done and overflow are 0 and quotient and remainder are all zeros.
- R2: When divisor is nonzero and greater than dividend[2W-1:W], then at done quotient equals floor(dividend/divisor), remainder equals dividend mod divisor, and overflow is 0.
- R3: When divisor is nonzero and not greater than dividend[2W-1:W], then at done overflow is 1, and quotient and remainder are all ones.
- R4: When divisor is zero, then at done overflow is 1, and quotient and remainder are all ones.
- R5: done is high for exactly one cycle. It rises W+1 clock edges after the edge that accepts start for a valid division, and 1 edge after it for an overflow request.
- R6: busy is 1 from the cycle after an accepted start up to and including the done cycle, and 0 in the cycle after done.
- R7: A start asserted while busy is ignored. The running division completes with the results and timing of the original operands.
- R8: While idle with start low, quotient, remainder and overflow keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division. Sampled only when idle |
| dividend | input | 2W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| busy | output | 1 | An operation is in progress, including the done cycle |
| done | output | 1 | One-cycle pulse when results are valid |
| overflow | output | 1 | Quotient would not fit, or divisor is zero |
| remainder | output | W | Remainder result |
| quotient | output | W | Quotient result |

## Verification
The bench drives its inputs on falling edges and samples the outputs on falling edges.

For a valid division, done and the final quotient and remainder are expected at the W+1-th falling edge after start is raised. For an overflow or zero-divisor request they are expected at the first falling edge. The bench checks that done is low at every earlier falling edge and that busy is high throughout.

One falling edge after done, the bench expects done and busy both low and the results unchanged. In every valid run it also raises start again with different operands at the second falling edge. It then expects the original answer at the original time.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } div_state_t;

endpackage

// File: rtl/div_step.sv
// One restoring step: shift the pair left, subtract the divisor when it fits.
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] t_in,
    input  logic [W-1:0] n_in,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] t_out,
    output logic [W-1:0] n_out
);
    logic [W:0] part;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        part  = {t_in, n_in[W-1]};
        fits  = (part >= {1'b0, d_in});
        diff  = part - {1'b0, d_in};
        t_out = fits ? diff[W-1:0] : part[W-1:0];
        n_out = {n_in[W-2:0], fits};
    end
endmodule

// File: rtl/div_guard.sv
// Detects a quotient that cannot fit in W bits (includes divide by zero).
module div_guard #(
    parameter int W = 16
) (
    input  logic [W-1:0] hi_half,
    input  logic [W-1:0] dvsr,
    output logic         no_fit
);
    always_comb begin
        no_fit = (dvsr == '0) || (dvsr <= hi_half);
    end
endmodule

// File: rtl/div_ctr.sv
// Step counter: flags the final step of a run.
module div_ctr #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic last
);
    localparam int CW = $clog2(W) + 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(W - 1));
endmodule

// File: rtl/shlsub_divider.sv
module shlsub_divider
    import div_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2*W-1:0] dividend,
    input  logic [W-1:0]   divisor,
    output logic           busy,
    output logic           done,
    output logic           overflow,
    output logic [W-1:0]   remainder,
    output logic [W-1:0]   quotient
);
    localparam int DW = 2 * W;

    div_state_t     state, state_nx;
    logic [W-1:0]   t_q, n_q, d_q;
    logic [W-1:0]   t_nx, n_nx;
    logic           ovf_q;
    logic           no_fit;
    logic           accept;
    logic           last_step;

    assign accept = start && (state == ST_IDLE);

    div_guard #(.W(W)) u_guard (
        .hi_half (dividend[DW-1:W]),
        .dvsr    (divisor),
        .no_fit  (no_fit)
    );

    div_step #(.W(W)) u_step (
        .t_in  (t_q),
        .n_in  (n_q),
        .d_in  (d_q),
        .t_out (t_nx),
        .n_out (n_nx)
    );

    div_ctr #(.W(W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (state == ST_RUN),
        .last  (last_step)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = no_fit ? ST_DONE : ST_RUN;
            ST_RUN:  if (last_step) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q   <= '0;
            n_q   <= '0;
            d_q   <= '0;
            ovf_q <= 1'b0;
        end else if (accept) begin
            d_q   <= divisor;
            ovf_q <= no_fit;
            if (no_fit) begin
                t_q <= '1;
                n_q <= '1;
            end else begin
                t_q <= dividend[DW-1:W];
                n_q <= dividend[W-1:0];
            end
        end else if (state == ST_RUN) begin
            t_q <= t_nx;
            n_q <= n_nx;
        end
    end

    assign remainder = t_q;
    assign quotient  = n_q;
    assign overflow  = ovf_q;
endmodule

// File: rtl/shlsub_divider_chk.sv
module shlsub_divider_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [2*W-1:0] dividend,
    input logic [W-1:0]   divisor,
    input logic           busy,
    input logic           done,
    input logic           overflow,
    input logic [W-1:0]   remainder,
    input logic [W-1:0]   quotient
);
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r7_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r3_no_fit: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor != '0 && divisor <= dividend[2*W-1:W])
            |=> (done && overflow));

    a_r4_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && divisor == '0) |=> (done && overflow));

    a_r3_ovf_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (quotient == '1 && remainder == '1));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(overflow)));
endmodule

bind shlsub_divider shlsub_divider_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dividend  (dividend),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .overflow  (overflow),
    .remainder (remainder),
    .quotient  (quotient)
);

// File: tb/sim_shlsub_divider.sv
`timescale 1ns/1ps
module sim_shlsub_divider;
    localparam int W  = 4;
    localparam int DW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] dividend = '0;
    logic [W-1:0]  divisor = '0;
    logic          busy, done, overflow;
    logic [W-1:0]  remainder, quotient;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    shlsub_divider #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .overflow(overflow),
        .remainder(remainder), .quotient(quotient)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_one(input int a, input int b);
        bit ovf_e;
        int q_e, r_e, lat;
        ovf_e = (b == 0) || (b <= (a >> W));
        q_e = ovf_e ? (1 << W) - 1 : a / b;
        r_e = ovf_e ? (1 << W) - 1 : a % b;
        lat = ovf_e ? 1 : W + 1;
        start    = 1'b1;
        dividend = DW'(a);
        divisor  = W'(b);
        for (int c = 1; c <= lat; c++) begin
            @(negedge clk);
            chk(busy == 1'b1, "R6 busy during op", int'(busy), 1);
            if (c < lat) begin
                chk(done == 1'b0, "R5 early done", int'(done), 0);
            end else begin
                chk(done == 1'b1, "R5 done timing", int'(done), 1);
                chk(overflow == ovf_e, ovf_e ? (b == 0 ? "R4 overflow" : "R3 overflow") : "R2 overflow",
                    int'(overflow), int'(ovf_e));
                chk(quotient == W'(q_e), ovf_e ? "R3/R4 quotient" : "R2 quotient",
                    int'(quotient), q_e);
                chk(remainder == W'(r_e), ovf_e ? "R3/R4 remainder" : "R2 remainder",
                    int'(remainder), r_e);
            end
            // R7: intrude with a second request while busy
            if (!ovf_e && c == 2) begin
                start    = 1'b1;
                dividend = ~DW'(a);
                divisor  = '0;
            end else begin
                start    = 1'b0;
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R5 single pulse", int'(done), 0);
        chk(busy == 1'b0, "R6 idle after done", int'(busy), 0);
        chk(quotient == W'(q_e) && remainder == W'(r_e), "R8 hold",
            int'({quotient, remainder}), int'({W'(q_e), W'(r_e)}));
    endtask

    initial begin
        #1_600_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && overflow == 1'b0, "R1 reset flags",
            int'({busy, done, overflow}), 0);
        chk(quotient == '0 && remainder == '0, "R1 reset results",
            int'({quotient, remainder}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int b = 0; b < (1 << W); b++) begin
            for (int a = 0; a < (1 << DW); a++) begin
                run_one(a, b);
            end
        end
        // R8: idle cycles with changing inputs but no start
        dividend = 8'h3C;
        divisor  = 4'h7;
        repeat (3) @(negedge clk);
        chk(quotient == 4'hF && remainder == 4'hF && overflow == 1'b1, "R8 idle hold",
            int'({overflow, quotient, remainder}), 9'h1FF);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule